// File: doc/BRIEF.md
# Mini UART Register Front-End

This block is the register side of a small UART. A 32-bit, word-oriented register port decodes offsets in a 256-byte window. Received bytes arrive through a ready/valid handshake and are kept in a circular receive queue. Software drains the queue through a data register. A byte that software writes to that same data register leaves at once as a one-cycle transmit strobe. Because transmission is taken to finish in the same cycle, the transmit side always reports itself empty and idle.

A single level interrupt combines two causes. The first is a receive cause: the receive interrupt is enabled and the queue holds data. The second is a transmit cause: the transmit interrupt is enabled. Since the transmitter is never busy, the transmit cause stays asserted for as long as it is enabled. Status words for line status, extended status and interrupt identification are composed from the queue fill level and the interrupt state.

Registers that have no function here read as zero and ignore writes. This covers line control, modem control, modem status, scratch, baud and any unknown offset.

Top module: `muart_regif`

## Requirements
- R1: While reset is high and in the first cycle after it, the queue is empty, both interrupt enables are clear, `irq` is low, `rx_ready` is high and `tx_strobe` is low.
- R2: A write at offset 0x44 keeps only bits 1:0 as the enables (bit 0 receive, bit 1 transmit). A read there returns those bits ORed with 0xC0.
- R3: `irq` is high exactly when (the receive enable is set and the queue is not empty) or the transmit enable is set.
- R4: A read at offset 0x48 returns 0xC0. Bit 2 is set if the queue holds data; otherwise bit 1 is set. Bit 0 is set when `irq` is low.
- R5: A write at offset 0x48 with bit 1 set empties the queue. A byte accepted in the same cycle is kept as the only entry. A write with bit 1 clear has no effect.
- R6: A read at offset 0x40 returns the oldest byte in bits 7:0 and removes it, with the position wrapping after the last slot. When the queue is empty, the read returns the byte in the slot the next read would use, and nothing changes.
- R7: A write at offset 0x40 raises `tx_strobe` for exactly the following cycle, with `tx_byte` equal to write data bits 7:0.
- R8: A read at offset 0x54 returns 0x60, with bit 0 set when the queue is not empty.
- R9: A read at offset 0x64 returns 0x30E. Bit 0 is set when the queue is not empty, and the fill count appears from bit 16 upward.
- R10: A read at 0x60 returns 0x3. A read at 0x04 returns 0x1. A read at 0x00 returns `irq` in bit 0.
- R11: `rx_ready` is high exactly while the fill count is below DEPTH (default 8). A byte is stored only when `rx_valid` and `rx_ready` are both high. It is stored in the slot DEPTH positions around from the oldest entry by the fill count.
- R12: Reads at 0x4C, 0x50, 0x58, 0x5C, 0x68 and any unlisted offset return 0. Writes there change nothing.
- R13: Read data appears on `bus_rdata` in the cycle after the request and holds until the next read. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte offset in the window |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| rx_valid | input | 1 | Receive byte offered |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Queue has room |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
Corruption of the fill count or the read position becomes visible within one cycle. It shows on `rx_ready` and `irq`, and on the next status or data read, where the wrong byte or count comes back. Sequences that fill the queue completely, drain it past the wrap point and then read it empty expose off-by-one position errors: the stale byte returned must be the first one written after the wrap. A flush that coincides with an arriving byte checks that the new byte lands at the oldest-entry slot and not after the discarded ones.

// File: rtl/muart_pkg.sv
package muart_pkg;
  // word indices (byte offset >> 2)
  localparam int W_AUXIRQ = 'h00;
  localparam int W_ENABLE = 'h01;
  localparam int W_DATA   = 'h10;
  localparam int W_IEN    = 'h11;
  localparam int W_IID    = 'h12;
  localparam int W_LSTAT  = 'h15;
  localparam int W_CTRL   = 'h18;
  localparam int W_XSTAT  = 'h19;

  localparam logic [7:0]  FIFO_ON_BITS = 8'hC0;
  localparam logic [7:0]  LSTAT_BASE   = 8'h60;
  localparam logic [31:0] XSTAT_BASE   = 32'h0000_030E;
  localparam int          XSTAT_CNT_LSB = 16;
  localparam int          IEN_RX = 0;
  localparam int          IEN_TX = 1;
  localparam int          FLUSH_BIT = 1;
endpackage

// File: rtl/muart_rxq.sv
module muart_rxq #(
  parameter int DEPTH = 8,
  parameter int BW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [BW-1:0] push_byte,
  input  logic          pop,
  input  logic          flush,
  output logic [BW-1:0] head_byte,
  output logic [CW-1:0] count
);
  logic [BW-1:0] mem [DEPTH];
  logic [PW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;
  logic [PW-1:0] slot;

  always_comb begin
    sum = (CW+1)'(head_q) + (flush ? '0 : (CW+1)'(cnt_q));
    if (sum >= (CW+1)'(DEPTH)) sum = sum - (CW+1)'(DEPTH);
    slot = sum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (push) mem[slot] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) head_q <= (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      if (flush) cnt_q <= push ? CW'(1) : '0;
      else       cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head_byte = mem[head_q];
  assign count     = cnt_q;
endmodule

// File: rtl/muart_irq.sv
module muart_irq
  import muart_pkg::*;
(
  input  logic [1:0] ien,
  input  logic       nonempty,
  output logic       irq,
  output logic [7:0] iid_byte
);
  logic rx_cause, tx_cause;
  assign rx_cause = ien[IEN_RX] & nonempty;
  assign tx_cause = ien[IEN_TX];
  assign irq      = rx_cause | tx_cause;
  always_comb begin
    iid_byte = FIFO_ON_BITS;
    iid_byte[2] = nonempty;
    iid_byte[1] = ~nonempty;
    iid_byte[0] = ~irq;
  end
endmodule

// File: rtl/muart_regif.sv
module muart_regif
  import muart_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_ready,
  output logic          tx_strobe,
  output logic [7:0]    tx_byte,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WI = AW - 2;

  logic [WI-1:0] widx;
  logic          rd_acc, wr_acc;
  logic [1:0]    ien_q;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    head_byte, iid_byte;
  logic          nonempty, push, pop, flush;
  logic [DW-1:0] rd_mux;

  assign widx   = bus_addr[AW-1:2];
  assign rd_acc = bus_req & ~bus_we;
  assign wr_acc = bus_req & bus_we;

  assign nonempty = (rx_cnt != '0);
  assign rx_ready = (rx_cnt < CW'(DEPTH));
  assign push     = rx_valid & rx_ready;
  assign pop      = rd_acc & (widx == WI'(W_DATA)) & nonempty;
  assign flush    = wr_acc & (widx == WI'(W_IID)) & bus_wdata[FLUSH_BIT];

  muart_rxq #(.DEPTH(DEPTH), .BW(8)) u_rxq (
    .clk(clk), .rst(rst), .push(push), .push_byte(rx_byte),
    .pop(pop), .flush(flush), .head_byte(head_byte), .count(rx_cnt)
  );

  muart_irq u_irq (
    .ien(ien_q), .nonempty(nonempty), .irq(irq), .iid_byte(iid_byte)
  );

  always_comb begin
    rd_mux = '0;
    case (widx)
      WI'(W_AUXIRQ): rd_mux = DW'(irq);
      WI'(W_ENABLE): rd_mux = DW'(1);
      WI'(W_DATA):   rd_mux = DW'(head_byte);
      WI'(W_IEN):    rd_mux = DW'(FIFO_ON_BITS | {6'b0, ien_q});
      WI'(W_IID):    rd_mux = DW'(iid_byte);
      WI'(W_LSTAT):  rd_mux = DW'(LSTAT_BASE | {7'b0, nonempty});
      WI'(W_CTRL):   rd_mux = DW'(3);
      WI'(W_XSTAT):  rd_mux = DW'(XSTAT_BASE) | DW'(nonempty)
                              | (DW'(rx_cnt) << XSTAT_CNT_LSB);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      ien_q     <= '0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      if (rd_acc) bus_rdata <= rd_mux;
      if (wr_acc && widx == WI'(W_IEN)) ien_q <= bus_wdata[1:0];
      tx_strobe <= wr_acc && (widx == WI'(W_DATA));
      if (wr_acc && widx == WI'(W_DATA)) tx_byte <= bus_wdata[7:0];
    end
  end
endmodule

// File: rtl/muart_regif_chk.sv
module muart_regif_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          tx_strobe,
  input logic [7:0]    tx_byte,
  input logic          irq,
  input logic [1:0]    ien_q,
  input logic [CW-1:0] rx_cnt
);
  logic wr_data, wr_flush, rd_data;
  assign wr_data  = bus_req && bus_we && (bus_addr[AW-1:2] == (AW-2)'('h10));
  assign rd_data  = bus_req && !bus_we && (bus_addr[AW-1:2] == (AW-2)'('h10));
  assign wr_flush = bus_req && bus_we && (bus_addr[AW-1:2] == (AW-2)'('h12)) && bus_wdata[1];

  a_r7_tx_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));
  a_r7_no_spurious_tx: assert property (@(posedge clk) disable iff (rst)
    !wr_data |=> !tx_strobe);
  a_r3_tx_cause: assert property (@(posedge clk) disable iff (rst)
    ien_q[1] |-> irq);
  a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
    (ien_q == 2'b00) |-> !irq);
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (rst)
    wr_flush |=> (rx_cnt <= CW'(1)));
  a_r11_full_holds: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == CW'(DEPTH) && !rd_data && !wr_flush) |=> (rx_cnt == CW'(DEPTH)));
endmodule

bind muart_regif muart_regif_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq),
  .ien_q(ien_q), .rx_cnt(rx_cnt)
);

// File: tb/muart_regif_tb_top.sv
`timescale 1ns/1ps
module muart_regif_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0, rx_valid = 0;
  logic [7:0] bus_addr = 0, rx_byte = 0, tx_byte;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rx_ready, tx_strobe, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  muart_regif dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  // behavioural reference
  int m_mem [8];
  int m_head = 0, m_cnt = 0, m_ier = 0;
  bit e_rv = 0, e_tx = 0;
  int e_rd = 0, e_txb = 0;
  string e_tag = "";

  function automatic bit m_irq();
    return ((m_ier & 1) != 0 && m_cnt > 0) || ((m_ier & 2) != 0);
  endfunction

  function automatic int m_read(int w);
    case (w)
      'h00: return m_irq() ? 1 : 0;
      'h01: return 1;
      'h10: return m_mem[m_head];
      'h11: return 'hC0 | m_ier;
      'h12: return 'hC0 | (m_cnt > 0 ? 4 : 2) | (m_irq() ? 0 : 1);
      'h15: return 'h60 | (m_cnt > 0 ? 1 : 0);
      'h18: return 3;
      'h19: return 'h30E | (m_cnt > 0 ? 1 : 0) | (m_cnt << 16);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int w);
    case (w)
      'h10: return "R6";
      'h11: return "R2";
      'h12: return "R4";
      'h15: return "R8";
      'h19: return "R9";
      'h00, 'h01, 'h18: return "R10";
      default: return "R12";
    endcase
  endfunction

  initial for (int i = 0; i < 8; i++) m_mem[i] = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_head = 0; m_cnt = 0; m_ier = 0; e_rv = 0; e_tx = 0;
    end else begin
      int w;
      bit pop, fl, push;
      w = int'(bus_addr) >> 2;
      e_rv = 0; e_tx = 0;
      if (bus_req && !bus_we) begin e_rv = 1; e_rd = m_read(w); e_tag = tag_of(w); end
      if (bus_req && bus_we && w == 'h10) begin e_tx = 1; e_txb = int'(bus_wdata[7:0]); end
      pop  = bus_req && !bus_we && w == 'h10 && m_cnt > 0;
      fl   = bus_req && bus_we && w == 'h12 && bus_wdata[1];
      push = rx_valid && m_cnt < 8;
      if (push) m_mem[(m_head + (fl ? 0 : m_cnt)) % 8] = int'(rx_byte);
      if (pop) m_head = (m_head + 1) % 8;
      m_cnt = (fl ? 0 : m_cnt - int'(pop)) + int'(push);
      if (bus_req && bus_we && w == 'h11) m_ier = int'(bus_wdata[1:0]);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 irq", int'(irq), int'(m_irq()));
      chk("R11 rx_ready", int'(rx_ready), int'(m_cnt < 8));
      chk("R7 tx_strobe", int'(tx_strobe), int'(e_tx));
      if (e_tx) chk("R7 tx_byte", int'(tx_byte), e_txb);
      if (e_rv) chk({e_tag, " rdata"}, int'(bus_rdata), e_rd);
    end
  end

  task automatic wr(int a, int d);
    bus_req = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = 32'(d);
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask
  task automatic rd(int a);
    bus_req = 1; bus_we = 0; bus_addr = 8'(a);
    @(negedge clk); bus_req = 0;
  endtask
  task automatic push(int b);
    rx_valid = 1; rx_byte = 8'(b);
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 rx_ready", int'(rx_ready), 1);
    chk("R1 tx_strobe", int'(tx_strobe), 0);
    rst = 0;
    idle(1);
    rd('h44);                         // R2 reset value 0xC0
    rd('h48);                         // R4 idle ident 0xC3
    wr('h44, 'hFD);                   // R2 keeps bit0 only
    rd('h44);
    push('h11); push('h22); push('h33);  // R3 rx cause
    rd('h48); rd('h54); rd('h64); rd('h00);
    rd('h40); rd('h40); rd('h40);     // R6 order
    wr('h44, 2);                      // R3 tx cause stays
    rd('h48); idle(2);
    wr('h44, 0);
    // R11 fill to depth, extra bytes refused
    for (int i = 0; i < 10; i++) push('hA0 + i);
    rd('h64); rd('h54);
    for (int i = 0; i < 8; i++) rd('h40);  // R6 drain across wrap
    rd('h40);                         // R6 empty read returns stale 0xA0
    chk("R6 stale byte", int'(bus_rdata), 'hA0);
    rd('h64);
    // R13 rdata holds
    idle(2);
    chk("R13 rdata hold", int'(bus_rdata), 'h30E);
    rd('h67);                         // R13 low address bits ignored
    // R5 flush with simultaneous byte
    push('h51); push('h52);
    rx_valid = 1; rx_byte = 8'h77;
    wr('h48, 'h2);
    rx_valid = 0;
    rd('h64);
    chk("R5 flush keeps new byte", int'(bus_rdata), 'h1030F);
    rd('h40);
    chk("R5 head after flush", int'(bus_rdata), 'h77);
    push('h61);
    wr('h48, 'h1);                    // R5 no flush
    rd('h64);
    // R7 transmit
    wr('h40, 'h1A5); wr('h40, 'h3C); idle(1);
    // simultaneous push and pop
    rx_valid = 1; rx_byte = 8'h99;
    rd('h40);
    rx_valid = 0;
    rd('h40); rd('h64);
    // R12 unimplemented offsets
    wr('h5C, 'hFF); rd('h5C); rd('h4C); rd('h50); rd('h58); rd('h68); rd('h80); rd('hFC);
    wr('h68, 'h3); rd('h44);          // write elsewhere left enables untouched
    rd('h60); rd('h04);               // R10 constants
    wr('h44, 'hFF); rd('h44); rd('h00);
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule